// File: doc/BRIEF.md
# Dual-Bank USB IN Endpoint Transmit Buffer

This block holds the outgoing data of one USB device IN endpoint in one or two packet banks. The CPU loads bytes into the bank it currently owns through a single byte port. Two flags show whether it may write: a bank-ready flag, which is also the interrupt source, and a FIFO-control flag that stays high while the CPU owns a bank. The CPU releases a full or partial bank by strobing a release input. This clears the FIFO-control flag, queues the bank for the host side and, with two banks, gives the CPU the other bank at once if that bank is empty.

On the host side, an IN token either gets a NAK pulse, when nothing is queued, or starts a stream of the oldest queued bank at one byte per cycle. A zero-length bank is reported by a separate pulse. The bank stays reserved until the host side reports an ACK. A second token before that ACK sends the same data again. A kill strobe throws away the newest queued bank that has not been picked up for sending. This is how firmware aborts the IN stage of a control or isochronous transfer when a zero-length OUT arrives.

Top module: `usb_in_bank_buf`

## Requirements
- R1: After reset the bank-ready flag, the FIFO-control flag and the write-allowed flag are 1, the byte count is 0, and no transmit output is active.
- R2: The interrupt output is 1 exactly when the bank-ready flag and the interrupt enable are both 1.
- R3: A pulse on the ready-acknowledge input clears the bank-ready flag on the next cycle, unless a new empty bank is handed to the CPU in that same cycle.
- R4: Each write accepted while write-allowed is 1 stores one byte in the CPU's bank and raises the byte count by one. A bank newly given to the CPU starts at count 0.
- R5: When the count reaches the endpoint size, write-allowed drops to 0. Later writes are ignored and the count stays unchanged.
- R6: A release while the FIFO-control flag is 1 queues the CPU's bank. If no empty bank remains, the FIFO-control and write-allowed flags read 0 and writes are ignored.
- R7: If an empty bank is available when the CPU releases its bank, or when an empty bank appears while the CPU owns none, the bank-ready and FIFO-control flags are both 1 on the next cycle and the count is 0.
- R8: An IN token with no queued bank gives a one-cycle NAK pulse on the next cycle. Otherwise, from the next cycle on, the oldest bank's bytes come out in the order they were written, one per cycle, with the last-byte marker on the final byte. A zero-length bank gives a one-cycle empty-packet pulse instead.
- R9: A host ACK after a bank has been sent frees that bank. A new token before the ACK resends the same bank.
- R10: A kill strobe discards the newest queued bank that is not reserved for sending. The bank then counts as empty, so a CPU that owned no bank gets it with bank-ready set.
- R11: A kill strobe with no eligible bank changes nothing: the CPU's count and data are kept, and a reserved bank can still be resent.
- R12: If the kill and release strobes arrive in the same cycle, the release is ignored.
- R13: A release and a host ACK in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Byte write strobe |
| cpu_wr_data | input | 8 | Byte to store |
| cpu_ack_rdy | input | 1 | Clears the bank-ready flag |
| cpu_release | input | 1 | Hands the CPU bank to the host side |
| cpu_kill | input | 1 | Discards the newest unsent queued bank |
| irq_en | input | 1 | Interrupt enable |
| rdy_flag | output | 1 | Bank-ready flag |
| fifoctl_flag | output | 1 | CPU currently owns a bank |
| wr_allow | output | 1 | Bank owned and not full |
| byte_cnt | output | $clog2(EPSIZE+1) | Bytes in the CPU bank |
| irq | output | 1 | Endpoint interrupt |
| tok_in | input | 1 | IN token received |
| host_ack | input | 1 | Host ACK received |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_nak | output | 1 | NAK pulse |
| tx_zlp | output | 1 | Zero-length packet pulse |

## Verification
The riskiest collision is a CPU release and a host ACK landing in the same cycle. The queued count must then stay level while both pointers move, and the CPU must keep an empty bank with bank-ready set. The bench provokes this by streaming the first bank, filling the second, and then driving release and ACK together. It judges the result from the flags and count on the next cycle and from the following token, which must stream exactly the second bank. Kill against release and kill against a reserved bank are exercised the same way.

// File: rtl/usb_in_bank_buf.sv
module usb_in_bank_buf #(
  parameter int NBANK  = 2,
  parameter int EPSIZE = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_wr_en,
  input  logic [7:0]                   cpu_wr_data,
  input  logic                         cpu_ack_rdy,
  input  logic                         cpu_release,
  input  logic                         cpu_kill,
  input  logic                         irq_en,
  output logic                         rdy_flag,
  output logic                         fifoctl_flag,
  output logic                         wr_allow,
  output logic [$clog2(EPSIZE+1)-1:0]  byte_cnt,
  output logic                         irq,
  input  logic                         tok_in,
  input  logic                         host_ack,
  output logic                         tx_valid,
  output logic [7:0]                   tx_data,
  output logic                         tx_last,
  output logic                         tx_nak,
  output logic                         tx_zlp
);
  localparam int CW = $clog2(EPSIZE+1);
  localparam int AW = $clog2(EPSIZE);

  logic [7:0]    mem  [NBANK][EPSIZE];
  logic [CW-1:0] blen [NBANK];
  logic          cpu_ptr, host_ptr;
  logic [1:0]    nfill;
  logic          inflight, busy;
  logic [AW-1:0] rd_idx;

  logic          rel_ok, kill_ok, kill_new, kill_old, ack_ok, start, wr_ok, grant, nak_now;
  logic [2:0]    nfill_n;

  function automatic logic nxt(input logic p);
    return (NBANK == 1) ? 1'b0 : ~p;
  endfunction

  assign rel_ok   = cpu_release && fifoctl_flag && !cpu_kill;
  assign kill_new = cpu_kill && nfill == 2'd2;
  assign kill_old = cpu_kill && nfill == 2'd1 && !inflight;
  assign kill_ok  = kill_new || kill_old;
  assign ack_ok   = host_ack && inflight && !busy;
  assign start    = tok_in && !busy && !host_ack && nfill != 2'd0 && !kill_old;
  assign nak_now  = tok_in && !busy && !host_ack && (nfill == 2'd0 || kill_old);
  assign wr_ok    = cpu_wr_en && wr_allow && !cpu_release && !cpu_kill;
  assign nfill_n  = 3'(nfill) + 3'(rel_ok) - 3'(ack_ok) - 3'(kill_ok);
  assign grant    = (nfill_n < 3'(NBANK)) && (rel_ok || !fifoctl_flag);

  assign wr_allow = fifoctl_flag && (byte_cnt < CW'(EPSIZE));
  assign irq      = rdy_flag && irq_en;
  assign tx_valid = busy;
  assign tx_data  = mem[host_ptr][rd_idx];
  assign tx_last  = busy && (CW'(rd_idx) == blen[host_ptr] - 1'b1);

  always_ff @(posedge clk)
    if (wr_ok) mem[cpu_ptr][byte_cnt[AW-1:0]] <= cpu_wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) blen[b] <= '0;
      cpu_ptr      <= 1'b0;
      host_ptr     <= 1'b0;
      nfill        <= 2'd0;
      byte_cnt     <= '0;
      fifoctl_flag <= 1'b1;
      rdy_flag     <= 1'b1;
      inflight     <= 1'b0;
      busy         <= 1'b0;
      rd_idx       <= '0;
      tx_nak       <= 1'b0;
      tx_zlp       <= 1'b0;
    end else begin
      nfill        <= nfill_n[1:0];
      fifoctl_flag <= nfill_n < 3'(NBANK);
      if (wr_ok) byte_cnt <= byte_cnt + 1'b1;
      if (rel_ok) begin
        blen[cpu_ptr] <= byte_cnt;
        cpu_ptr       <= nxt(cpu_ptr);
      end
      if (rel_ok || grant) byte_cnt <= '0;
      if (kill_new) cpu_ptr <= nxt(cpu_ptr);
      if (grant) rdy_flag <= 1'b1;
      else if (cpu_ack_rdy) rdy_flag <= 1'b0;
      if (kill_old || ack_ok) host_ptr <= nxt(host_ptr);
      if (ack_ok) inflight <= 1'b0;
      tx_nak <= nak_now;
      tx_zlp <= start && blen[host_ptr] == '0;
      if (start) begin
        inflight <= 1'b1;
        busy     <= blen[host_ptr] != '0;
        rd_idx   <= '0;
      end else if (busy) begin
        if (tx_last) busy <= 1'b0;
        else rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> byte_cnt == $past(byte_cnt) + 1'b1);
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CW'(EPSIZE));
  a_r6_no_write_without_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoctl_flag |-> !wr_allow);
  a_r8_single_packet_end: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |=> !tx_valid);
  a_r8_zlp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> !tx_valid && !tx_nak);
  a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nfill <= 2'(NBANK));
endmodule

// File: tb/usb_in_bank_buf_bench.sv
module usb_in_bank_buf_bench;
  logic clk = 0, rst_n = 0;
  logic cpu_wr_en = 0, cpu_ack_rdy = 0, cpu_release = 0, cpu_kill = 0, irq_en = 0;
  logic [7:0] cpu_wr_data = 0;
  logic tok_in = 0, host_ack = 0;
  logic rdy_flag, fifoctl_flag, wr_allow, irq, tx_valid, tx_last, tx_nak, tx_zlp;
  logic [6:0] byte_cnt;
  logic [7:0] tx_data;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  usb_in_bank_buf #(.NBANK(2), .EPSIZE(64)) u_usb_in_bank_buf (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_ack_rdy(cpu_ack_rdy), .cpu_release(cpu_release), .cpu_kill(cpu_kill),
    .irq_en(irq_en), .rdy_flag(rdy_flag), .fifoctl_flag(fifoctl_flag),
    .wr_allow(wr_allow), .byte_cnt(byte_cnt), .irq(irq), .tok_in(tok_in),
    .host_ack(host_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_nak(tx_nak), .tx_zlp(tx_zlp));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [15:0] VEC [6] = '{
    {8'd5, 8'h10}, {8'd1, 8'hA0}, {8'd64, 8'h00},
    {8'd0, 8'h55}, {8'd17, 8'h33}, {8'd63, 8'hF0}};

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      cpu_wr_en = 1; cpu_wr_data = seed + 8'(i); cyc();
    end
    cpu_wr_en = 0;
  endtask

  task automatic pulse_rel();
    cpu_release = 1; cyc(); cpu_release = 0;
  endtask

  task automatic pulse_ack();
    host_ack = 1; cyc(); host_ack = 0;
  endtask

  task automatic clr_rdy();
    cpu_ack_rdy = 1; cyc(); cpu_ack_rdy = 0;
  endtask

  task automatic expect_stream(input string req, input int n, input logic [7:0] seed);
    tok_in = 1; cyc(); tok_in = 0;
    if (n == 0) begin
      chk(req, int'({tx_zlp, tx_valid}), 2);
      cyc();
    end else begin
      for (int i = 0; i < n; i++) begin
        chk(req, int'({tx_valid, tx_last, tx_data}),
            int'({1'b1, (i == n - 1), seed + 8'(i)}));
        cyc();
      end
      chk(req, int'(tx_valid), 0);
    end
  endtask

  task automatic expect_nak(input string req);
    tok_in = 1; cyc(); tok_in = 0;
    chk(req, int'({tx_nak, tx_valid}), 2);
    cyc();
  endtask

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk("R1", int'({rdy_flag, fifoctl_flag, wr_allow, tx_valid, tx_nak, tx_zlp}), 56);
    chk("R1 count", int'(byte_cnt), 0);
    // R2 interrupt gating
    chk("R2 disabled", int'(irq), 0);
    irq_en = 1; #1;
    chk("R2 enabled", int'(irq), 1);
    // R3 acknowledge
    clr_rdy();
    chk("R3", int'({rdy_flag, irq}), 0);

    foreach (VEC[k]) begin
      int n; logic [7:0] s;
      n = int'(VEC[k][15:8]); s = VEC[k][7:0];
      wr(n, s);
      chk("R4 count", int'(byte_cnt), n);
      if (n == 64) begin
        chk("R5 full", int'(wr_allow), 0);
        wr(1, 8'hEE);
        chk("R5 ignored", int'(byte_cnt), 64);
      end
      pulse_rel();
      chk("R7 next bank", int'({rdy_flag, fifoctl_flag, wr_allow}), 7);
      chk("R4 new bank count", int'(byte_cnt), 0);
      expect_stream("R8 stream", n, s);
      pulse_ack();
      clr_rdy();
    end

    expect_nak("R8 nak");

    // R6 both banks queued
    wr(3, 8'h20); pulse_rel(); wr(4, 8'h30); pulse_rel();
    chk("R6 no bank", int'({fifoctl_flag, wr_allow}), 0);
    wr(2, 8'h99);
    chk("R6 write ignored", int'(byte_cnt), 0);
    clr_rdy();
    expect_stream("R8 oldest", 3, 8'h20);
    expect_stream("R9 resend", 3, 8'h20);
    pulse_ack();
    chk("R9 freed", int'({rdy_flag, fifoctl_flag}), 3);
    expect_stream("R9 next", 4, 8'h30);
    pulse_ack();
    expect_nak("R9 empty");
    clr_rdy();

    // R11 kill with nothing queued
    wr(2, 8'h70);
    cpu_kill = 1; cyc(); cpu_kill = 0;
    chk("R11 no effect", int'({fifoctl_flag, byte_cnt}), 130);
    pulse_rel();
    // R10 kill the only queued bank
    cpu_kill = 1; cyc(); cpu_kill = 0;
    expect_nak("R10 killed");
    clr_rdy();

    // R10 kill newest while oldest reserved
    wr(2, 8'h40); pulse_rel(); wr(3, 8'h50); pulse_rel();
    clr_rdy();
    expect_stream("R10 oldest", 2, 8'h40);
    cpu_kill = 1; cyc(); cpu_kill = 0;
    chk("R10 regrant", int'({rdy_flag, fifoctl_flag, byte_cnt}), 256 + 128);
    pulse_ack();
    expect_nak("R10 newest gone");

    // R11 kill with only a reserved bank
    wr(2, 8'h60); pulse_rel();
    expect_stream("R11 first", 2, 8'h60);
    cpu_kill = 1; cyc(); cpu_kill = 0;
    expect_stream("R11 resend", 2, 8'h60);
    pulse_ack();

    // R12 kill and release together
    wr(3, 8'h80);
    cpu_kill = 1; cpu_release = 1; cyc(); cpu_kill = 0; cpu_release = 0;
    chk("R12 release ignored", int'({fifoctl_flag, byte_cnt}), 128 + 3);
    expect_nak("R12 nothing queued");
    pulse_rel();
    expect_stream("R12 data kept", 3, 8'h80);
    pulse_ack();
    clr_rdy();

    // R13 release and ACK together
    wr(2, 8'hB0); pulse_rel();
    expect_stream("R13 first", 2, 8'hB0);
    wr(4, 8'hC0);
    clr_rdy();
    cpu_release = 1; host_ack = 1; cyc(); cpu_release = 0; host_ack = 0;
    chk("R13 flags", int'({rdy_flag, fifoctl_flag, byte_cnt}), 256 + 128);
    expect_stream("R13 second", 4, 8'hC0);
    pulse_ack();
    expect_nak("R13 drained");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule